// File: doc/BRIEF.md
# Sampling Tap Correction Controller

This block holds the sampling-clock tap used by a high-speed SD/eMMC receive path. After a command completes, the command engine raises a one-cycle evaluate strobe. The controller then looks at the correction request word and, in the double-data-rate mode, at the command-line compare flags. It either leaves the tap alone, steps it one position around a ring of 4 or 8 taps, or raises a one-cycle retune request so that software runs a full tuning pass again.

There are two correction modes. In automatic mode only the error flag matters, and the block just reports it. In manual mode the block steps the tap itself. In the double-data-rate mode a step that would land on a tap marked bad is refused. The block then checks the saved compare result of the tap on the other side of the current one to decide whether a retune is needed. A strobe to clear the request word goes out whenever the word has been used. The tap is sent to the delay line halved when the ring has four taps.

Top module: `tap_corrector`

## Requirements
- R1: After reset the internal tap is 0, `dly_tap_o` is 0, and `retune_o` and `req_clr_o` are low.
- R2: The tap, `retune_o` and `req_clr_o` change only in the cycle after an `eval_i` strobe. Each pulse is high for exactly that one cycle. With no strobe the tap holds.
- R3: With `auto_i` high, a strobe whose request word has the error flag (bit 2) set raises `req_clr_o` and `retune_o` and leaves the tap alone. Any other word, including one with only the up flag (bit 1) or only the down flag (bit 0), has no effect.
- R4: In manual mode (`auto_i` low), an all-zero request word has no effect. Any nonzero word raises `req_clr_o`.
- R5: In manual mode with `ddr_i` low, the flags are taken in priority order: error (bit 2) first, then up (bit 1), then down (bit 0). The error flag raises `retune_o` and leaves the tap alone.
- R6: A step up gives (tap+1) mod N and a step down gives (tap+N-1) mod N. N is 4 when `four_i` is high and 8 when it is low.
- R7: In manual mode with `ddr_i` high, and a nonzero request word, only `cmd_cmp_i` decides the action: bit 1 alone steps up, bit 0 alone steps down, both bits raise `retune_o`, and neither bit only clears.
- R8: In the double-data-rate mode, a step whose new tap has its bit set in `bad_mask_i` leaves the tap unchanged. `retune_o` then rises exactly when `saved_cmp_i` has the bit set for the tap one position opposite the step direction.
- R9: `dly_tap_o` equals the tap shifted right by one when `four_i` is high, and the tap itself otherwise.
- R10: While `tuned_i` is low, `eval_i` strobes are ignored: no pulse and no tap change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | One-cycle strobe after a command completes |
| tuned_i | input | 1 | A tuned high-speed mode is selected |
| auto_i | input | 1 | Automatic correction mode |
| ddr_i | input | 1 | Double-data-rate mode |
| four_i | input | 1 | Ring of four taps (else TAP_MAX) |
| req_i | input | 3 | Request word: bit 2 error, bit 1 up, bit 0 down |
| cmd_cmp_i | input | 2 | Command compare flags: bit 1 up, bit 0 down |
| bad_mask_i | input | TAP_MAX | Taps that must not be used in the double-data-rate mode |
| saved_cmp_i | input | TAP_MAX | Per-tap compare result kept from the last tuning pass |
| dly_tap_o | output | TAP_W | Tap value for the delay line |
| retune_o | output | 1 | One-cycle retune request |
| req_clr_o | output | 1 | One-cycle clear strobe for the request word |

## Verification
The bench builds the block with the default TAP_MAX of 8, so both ring sizes (8, and 4 through `four_i`) are reachable. It sweeps all eight request words in both manual single-rate and automatic modes, and steps repeatedly past both ends of each ring to exercise wraparound. In the double-data-rate mode it crosses all four compare-flag patterns with several bad-tap masks and saved-compare maps, which covers both the blocked-step retune and the silent hold. The inactive sweep and the idle cycles after each strobe check that nothing moves without a valid strobe.

// File: rtl/tapc_pkg.sv
package tapc_pkg;

  localparam int REQ_W       = 3;
  localparam int REQ_ERR_BIT = 2;
  localparam int REQ_UP_BIT  = 1;
  localparam int REQ_DN_BIT  = 0;

  localparam int CMP_W       = 2;
  localparam int CMP_UP_BIT  = 1;
  localparam int CMP_DN_BIT  = 0;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_CLEAR  = 2'd1,
    ACT_STEP   = 2'd2,
    ACT_RETUNE = 2'd3
  } tap_act_e;

endpackage

// File: rtl/tapc_decide.sv
module tapc_decide
  import tapc_pkg::*;
#(
  parameter int TAP_MAX = 8,
  localparam int TAP_W  = $clog2(TAP_MAX)
) (
  input  logic               eval_i,
  input  logic               tuned_i,
  input  logic               auto_i,
  input  logic               ddr_i,
  input  logic               four_i,
  input  logic [REQ_W-1:0]   req_i,
  input  logic [CMP_W-1:0]   cmd_cmp_i,
  input  logic [TAP_MAX-1:0] bad_mask_i,
  input  logic [TAP_MAX-1:0] saved_cmp_i,
  input  logic [TAP_W-1:0]   cur_tap_i,
  output tap_act_e           act_o,
  output logic [TAP_W-1:0]   new_tap_o
);

  localparam logic [TAP_W-1:0] LIM_FULL = TAP_W'(TAP_MAX - 1);
  localparam logic [TAP_W-1:0] LIM_HALF = TAP_W'(TAP_MAX / 2 - 1);

  function automatic logic [TAP_W-1:0] ring_mask(input logic four);
    return four ? LIM_HALF : LIM_FULL;
  endfunction

  function automatic logic [TAP_W-1:0] ring_inc(input logic [TAP_W-1:0] t,
                                                input logic four);
    return (t + TAP_W'(1)) & ring_mask(four);
  endfunction

  function automatic logic [TAP_W-1:0] ring_dec(input logic [TAP_W-1:0] t,
                                                input logic four);
    return (t - TAP_W'(1)) & ring_mask(four);
  endfunction

  logic             take;
  logic             ddr_single;
  logic [TAP_W-1:0] prop_tap;
  logic [TAP_W-1:0] opp_tap;
  logic             prop_bad;
  logic             opp_saved;
  tap_act_e         act;

  // Named events for the checks below
  logic ev_step;
  logic ev_blocked;

  assign take = eval_i && tuned_i;

  always_comb begin
    ddr_single = 1'b0;
    prop_tap   = cur_tap_i;
    opp_tap    = cur_tap_i;
    unique case (cmd_cmp_i)
      2'b10: begin
        ddr_single = 1'b1;
        prop_tap   = ring_inc(cur_tap_i, four_i);
        opp_tap    = ring_dec(cur_tap_i, four_i);
      end
      2'b01: begin
        ddr_single = 1'b1;
        prop_tap   = ring_dec(cur_tap_i, four_i);
        opp_tap    = ring_inc(cur_tap_i, four_i);
      end
      default: ;
    endcase
  end

  assign prop_bad  = bad_mask_i[prop_tap];
  assign opp_saved = saved_cmp_i[opp_tap];

  always_comb begin
    act       = ACT_IDLE;
    new_tap_o = cur_tap_i;
    if (take) begin
      if (auto_i) begin
        if (req_i[REQ_ERR_BIT]) act = ACT_RETUNE;
      end else if (req_i != '0) begin
        act = ACT_CLEAR;
        if (ddr_i) begin
          if (cmd_cmp_i[CMP_UP_BIT] && cmd_cmp_i[CMP_DN_BIT]) begin
            act = ACT_RETUNE;
          end else if (ddr_single) begin
            if (prop_bad) begin
              act = opp_saved ? ACT_RETUNE : ACT_CLEAR;
            end else begin
              act       = ACT_STEP;
              new_tap_o = prop_tap;
            end
          end
        end else begin
          if (req_i[REQ_ERR_BIT]) begin
            act = ACT_RETUNE;
          end else if (req_i[REQ_UP_BIT]) begin
            act       = ACT_STEP;
            new_tap_o = ring_inc(cur_tap_i, four_i);
          end else if (req_i[REQ_DN_BIT]) begin
            act       = ACT_STEP;
            new_tap_o = ring_dec(cur_tap_i, four_i);
          end
        end
      end
    end
  end

  assign act_o      = act;
  assign ev_step    = (act == ACT_STEP);
  assign ev_blocked = take && !auto_i && ddr_i && (req_i != '0) && ddr_single && prop_bad;

  // R8: a double-data-rate step never lands on a bad tap
  always_comb begin
    if (ev_step && ddr_i) a_r8_no_bad_landing : assert (!bad_mask_i[new_tap_o]);
  end

  // R6: a stepped tap stays inside the selected ring
  always_comb begin
    if (ev_step) a_r6_step_in_ring : assert ((new_tap_o & ~ring_mask(four_i)) == '0);
  end

  // R8: a blocked step never moves the tap
  always_comb begin
    if (ev_blocked) a_r8_blocked_holds : assert (new_tap_o == cur_tap_i);
  end

endmodule

// File: rtl/tapc_track.sv
module tapc_track
  import tapc_pkg::*;
#(
  parameter int TAP_MAX = 8,
  localparam int TAP_W  = $clog2(TAP_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tap_act_e         act_i,
  input  logic [TAP_W-1:0] new_tap_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             retune_o,
  output logic             clr_o
);

  logic [TAP_W-1:0] tap_q;
  logic             retune_q;
  logic             clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q    <= '0;
      retune_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      if (act_i == ACT_STEP) tap_q <= new_tap_i;
      retune_q <= (act_i == ACT_RETUNE);
      clr_q    <= (act_i != ACT_IDLE);
    end
  end

  assign tap_o    = tap_q;
  assign retune_o = retune_q;
  assign clr_o    = clr_q;

  // R2: the tap only moves after a step decision
  a_r2_tap_moves_on_step : assert property (@(posedge clk) disable iff (!rst_n)
    (act_i != ACT_STEP) |=> $stable(tap_q));

  // R5: a retune pulse always comes with the clear strobe
  a_r5_retune_clears : assert property (@(posedge clk) disable iff (!rst_n)
    retune_q |-> clr_q);

endmodule

// File: rtl/tapc_map.sv
module tapc_map #(
  parameter int TAP_MAX = 8,
  localparam int TAP_W  = $clog2(TAP_MAX)
) (
  input  logic             four_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W-1:0] dly_o
);

  function automatic logic [TAP_W-1:0] halve(input logic [TAP_W-1:0] t);
    return t >> 1;
  endfunction

  generate
    if (TAP_W > 1) begin : g_shift
      assign dly_o = four_i ? halve(tap_i) : tap_i;
    end else begin : g_pass
      logic unused_four;
      assign unused_four = four_i;
      assign dly_o = tap_i;
    end
  endgenerate

endmodule

// File: rtl/tap_corrector.sv
module tap_corrector
  import tapc_pkg::*;
#(
  parameter int TAP_MAX = 8,
  localparam int TAP_W  = $clog2(TAP_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eval_i,
  input  logic               tuned_i,
  input  logic               auto_i,
  input  logic               ddr_i,
  input  logic               four_i,
  input  logic [2:0]         req_i,
  input  logic [1:0]         cmd_cmp_i,
  input  logic [TAP_MAX-1:0] bad_mask_i,
  input  logic [TAP_MAX-1:0] saved_cmp_i,
  output logic [TAP_W-1:0]   dly_tap_o,
  output logic               retune_o,
  output logic               req_clr_o
);

  tap_act_e         act;
  logic [TAP_W-1:0] new_tap;
  logic [TAP_W-1:0] cur_tap;

  tapc_decide #(.TAP_MAX(TAP_MAX)) u_decide (
    .eval_i      (eval_i),
    .tuned_i     (tuned_i),
    .auto_i      (auto_i),
    .ddr_i       (ddr_i),
    .four_i      (four_i),
    .req_i       (req_i),
    .cmd_cmp_i   (cmd_cmp_i),
    .bad_mask_i  (bad_mask_i),
    .saved_cmp_i (saved_cmp_i),
    .cur_tap_i   (cur_tap),
    .act_o       (act),
    .new_tap_o   (new_tap)
  );

  tapc_track #(.TAP_MAX(TAP_MAX)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (act),
    .new_tap_i (new_tap),
    .tap_o     (cur_tap),
    .retune_o  (retune_o),
    .clr_o     (req_clr_o)
  );

  tapc_map #(.TAP_MAX(TAP_MAX)) u_map (
    .four_i (four_i),
    .tap_i  (cur_tap),
    .dly_o  (dly_tap_o)
  );

  // R2: the clear strobe only follows an evaluate strobe
  a_r2_clr_after_eval : assert property (@(posedge clk) disable iff (!rst_n)
    req_clr_o |-> $past(eval_i));

  // R10: strobes while inactive change nothing
  a_r10_inactive_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !tuned_i) |=> (!req_clr_o && !retune_o && $stable(cur_tap)));

  // R3: in automatic mode the tap never moves
  a_r3_auto_no_step : assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && auto_i) |=> $stable(cur_tap));

  // R4: a zero request word in manual mode is ignored
  a_r4_zero_word_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !auto_i && (req_i == 3'b000)) |=> !req_clr_o);

endmodule

// File: tb/tap_corrector_test.sv
module tap_corrector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eval_i = 1'b0;
  logic       tuned_i = 1'b1;
  logic       auto_i = 1'b0;
  logic       ddr_i = 1'b0;
  logic       four_i = 1'b0;
  logic [2:0] req_i = '0;
  logic [1:0] cmd_cmp_i = '0;
  logic [7:0] bad_mask_i = '0;
  logic [7:0] saved_cmp_i = '0;
  logic [2:0] dly_tap_o;
  logic       retune_o;
  logic       req_clr_o;

  int n_checks = 0;
  int n_fail = 0;
  int m_tap = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tap_corrector uut (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .tuned_i(tuned_i),
    .auto_i(auto_i), .ddr_i(ddr_i), .four_i(four_i), .req_i(req_i),
    .cmd_cmp_i(cmd_cmp_i), .bad_mask_i(bad_mask_i), .saved_cmp_i(saved_cmp_i),
    .dly_tap_o(dly_tap_o), .retune_o(retune_o), .req_clr_o(req_clr_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_dly(input int t);
    return four_i ? t / 2 : t;
  endfunction

  // Apply one evaluate strobe and check the result against a bench model.
  task automatic apply(input logic [2:0] rq, input logic [1:0] cm, input string tag);
    int n, nt, ot, e_rt, e_clr;
    n = four_i ? 4 : 8;
    e_rt = 0; e_clr = 0;
    if (tuned_i) begin
      if (auto_i) begin
        if (rq[2]) begin e_rt = 1; e_clr = 1; end
      end else if (rq != 3'b000) begin
        e_clr = 1;
        if (ddr_i) begin
          if (cm == 2'b11) e_rt = 1;
          else if (cm != 2'b00) begin
            if (cm == 2'b10) begin nt = (m_tap + 1) % n; ot = (m_tap + n - 1) % n; end
            else begin nt = (m_tap + n - 1) % n; ot = (m_tap + 1) % n; end
            if (bad_mask_i[nt]) e_rt = saved_cmp_i[ot] ? 1 : 0;
            else m_tap = nt;
          end
        end else begin
          if (rq[2]) e_rt = 1;
          else if (rq[1]) m_tap = (m_tap + 1) % n;
          else if (rq[0]) m_tap = (m_tap + n - 1) % n;
        end
      end
    end
    @(negedge clk);
    req_i = rq; cmd_cmp_i = cm; eval_i = 1'b1;
    @(negedge clk);
    eval_i = 1'b0;
    chk({tag, " tap"}, int'(dly_tap_o), exp_dly(m_tap));
    chk({tag, " retune"}, int'(retune_o), e_rt);
    chk({tag, " clear"}, int'(req_clr_o), e_clr);
    @(negedge clk);
    chk("R2 pulse drop", int'(retune_o) + int'(req_clr_o), 0);
    chk("R2 tap hold", int'(dly_tap_o), exp_dly(m_tap));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tap", int'(dly_tap_o), 0);
    chk("R1 pulses", int'(retune_o) + int'(req_clr_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 idle tap", int'(dly_tap_o), 0);
    chk("R2 idle pulses", int'(retune_o) + int'(req_clr_o), 0);

    // Manual single-rate sweep, both ring sizes (R4 R5 R6 R9)
    for (int f = 0; f < 2; f++) begin
      four_i = f[0];
      for (int r = 0; r < 8; r++) begin
        apply(3'(r), 2'b00, "R5");
        apply(3'(r), 2'b11, "R4");
      end
      for (int k = 0; k < 10; k++) apply(3'b010, 2'b00, "R6 up");
      for (int k = 0; k < 11; k++) apply(3'b001, 2'b00, "R9 down");
    end

    // Automatic mode: only the error flag matters (R3)
    auto_i = 1'b1;
    for (int f = 0; f < 2; f++) begin
      four_i = f[0];
      ddr_i = f[0];
      for (int r = 0; r < 8; r++) apply(3'(r), 2'(r), "R3");
    end
    auto_i = 1'b0;

    // Double-data-rate sweep (R7 R8)
    ddr_i = 1'b1;
    for (int f = 0; f < 2; f++) begin
      four_i = f[0];
      for (int b = 0; b < 4; b++) begin
        bad_mask_i = (b == 0) ? 8'h00 : (b == 1) ? 8'hCC : (b == 2) ? 8'hAA : 8'hFF;
        for (int s = 0; s < 3; s++) begin
          saved_cmp_i = (s == 0) ? 8'h00 : (s == 1) ? 8'hFF : 8'h55;
          for (int c = 0; c < 4; c++) begin
            apply(3'b001, 2'(c), "R7");
            apply(3'b100, 2'b10, "R8");
          end
          apply(3'b000, 2'b10, "R4 ddr zero");
        end
      end
    end
    bad_mask_i = 8'h00;
    for (int k = 0; k < 9; k++) apply(3'b010, 2'b10, "R7 walk");

    // Inactive: strobes ignored (R10)
    tuned_i = 1'b0;
    for (int r = 0; r < 8; r++) begin
      ddr_i = r[0];
      apply(3'(r), 2'(r), "R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule